// File: doc/BRIEF.md
# Adder-Shared Integer Compare Unit

This block is the add/compare datapath of a 64-bit integer execute stage. A single carry-propagate adder serves two kinds of operation. For an add, it forms the sum of operand A (optionally inverted) and operand B plus a carry-in. It also reports the carries out of bit 31 and bit 63 and the signed overflow at both widths. For a compare, the same adder always forms B minus A. Its carry, together with the sign bits of the operands, ranks the operands for both signed and unsigned compares. A separate XOR reduction over the operands supplies equality, so there is no magnitude comparator of its own.

A compare result is a 4-bit condition field. The field is copied into every nibble of a 32-bit condition write bus. A one-hot nibble mask, chosen by a 3-bit field number, tells the condition register which nibble to commit. All outputs are registered, so results appear one cycle after the operation is accepted.

Top module: `addcmp_unit`

## Requirements
- R1: An add (`op_cmp`=0) accepted with `in_valid`=1 yields `sum` = (A, or ~A when `inv_a`=1) + B + `carry_in` modulo 2^64. `sum_valid`=1 and `cr_we`=0 on the following cycle.
- R2: On an add, `ca` is the carry out of bit 63 and `ca32` is the carry out of bit 31. `ca_upd`=1 only when `carry_en`=1.
- R3: On an add, `ov` is 1 when the two addend sign bits (bit 63) agree and the sum sign bit differs from them. `ov32` follows the same rule at bit 31. `ov_upd`=1 only when `ov_en`=1.
- R4: The condition field has LT in bit 3, GT in bit 2, EQ in bit 1 and SO in bit 0, where SO is `so_in`. Equal operands give 0,0,1,SO. In 32-bit mode (`cmp_wide`=0) only bits 31:0 take part in equality; in 64-bit mode all 64 bits do.
- R5: For a signed compare (`cmp_signed`=1) whose selected sign bits differ, the operand with sign bit 0 is greater. The selected sign bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode.
- R6: For an unsigned compare (`cmp_signed`=0) whose selected sign bits differ, the operand with top bit 1 is greater.
- R7: When the selected top bits are equal and the operands are unequal, LT=1 exactly when A < B at the selected width. Bits above 31 have no effect in 32-bit mode. A non-equal result is LT, NOT LT, 0, SO.
- R8: A compare sets `cr_we`=1 and repeats the field in all eight nibbles of `cr_data`. `cr_mask` is one-hot with bit (7 − `field_sel`) set, so field 0 selects `cr_data[31:28]` and field 7 selects `cr_data[3:0]`.
- R9: A compare always computes B − A, whatever `inv_a` and `carry_in` are. It never raises `sum_valid`, `ca_upd` or `ov_upd`, even when `carry_en` or `ov_en` is set.
- R10: `out_valid` is `in_valid` delayed by one cycle. No strobe (`sum_valid`, `cr_we`, `ca_upd`, `ov_upd`) is raised in a cycle that follows one without `in_valid`.
- R11: While reset is held and right after it, every valid and strobe output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_cmp | input | 1 | 1 = compare, 0 = add |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| inv_a | input | 1 | Invert A for an add |
| carry_in | input | 1 | Carry-in for an add |
| carry_en | input | 1 | Report carry flags for an add |
| ov_en | input | 1 | Report overflow flags for an add |
| cmp_signed | input | 1 | Signed compare when 1, unsigned when 0 |
| cmp_wide | input | 1 | 64-bit compare when 1, 32-bit compare when 0 |
| field_sel | input | 3 | Target condition field number |
| so_in | input | 1 | Sticky overflow copied into the field |
| out_valid | output | 1 | Registered result present |
| sum_valid | output | 1 | Registered add result valid |
| sum | output | 64 | Adder result |
| ca | output | 1 | Carry out of bit 63 |
| ca32 | output | 1 | Carry out of bit 31 |
| ca_upd | output | 1 | Carry flags to be written |
| ov | output | 1 | 64-bit signed overflow |
| ov32 | output | 1 | 32-bit signed overflow |
| ov_upd | output | 1 | Overflow flags to be written |
| cr_data | output | 32 | Condition field repeated in all nibbles |
| cr_mask | output | 8 | One-hot nibble commit mask |
| cr_we | output | 1 | Condition register write enable |

## Verification
Every output is a register loaded one edge after the operation is accepted. Any fault in the operand steering, the carry taps or the ordering logic therefore shows up in the very next cycle's `cr_data`, `sum` or flag outputs. An add or compare strobe raised for the wrong operation kind appears on the same cycle as the result. A wrong mask decode shows as a mask bit away from 7 − `field_sel`. Width mistakes reveal themselves only with operands whose upper and lower halves rank differently, so the stimulus pairs such operands with both width settings.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned NFIELD  = 8;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;

  localparam int unsigned FIELD_W = $bits(crf_t);
endpackage

// File: rtl/addcmp_adder.sv
module addcmp_adder #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         inv,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         co_full,
  output logic         co_half,
  output logic         ov_full,
  output logic         ov_half
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] a_eff;
  logic [W:0]   total;

  always_comb begin
    a_eff   = inv ? ~a : a;
    total   = {1'b0, a_eff} + {1'b0, b} + {{W{1'b0}}, cin};
    sum     = total[W-1:0];
    co_full = total[W];
    // carry into bit H recovered from the sum bit and its addends
    co_half = total[H] ^ a_eff[H] ^ b[H];
    ov_full = (a_eff[W-1] == b[W-1]) && (total[W-1] != a_eff[W-1]);
    ov_half = (a_eff[H-1] == b[H-1]) && (total[H-1] != a_eff[H-1]);
  end
endmodule

// File: rtl/addcmp_cond.sv
module addcmp_cond
  import addcmp_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         wide,
  input  logic         sgn,
  input  logic         co_full,
  input  logic         co_half,
  input  logic         so,
  output crf_t         fld
);
  localparam int unsigned H = W / 2;

  logic eq_lo, eq_hi, same;
  logic top_a, top_b, a_lt;

  always_comb begin
    eq_lo = ~|(a[H-1:0] ^ b[H-1:0]);
    eq_hi = ~|(a[W-1:H] ^ b[W-1:H]);
    same  = eq_lo && (!wide || eq_hi);
    top_a = wide ? a[W-1] : a[H-1];
    top_b = wide ? b[W-1] : b[H-1];
    if (top_a != top_b) begin
      // order settled by the top bits alone
      a_lt = sgn ? top_a : ~top_a;
    end else begin
      // B - A produced no borrow, and the operands differ: A below B
      a_lt = wide ? co_full : co_half;
    end
    if (same) begin
      fld = '{lt: 1'b0, gt: 1'b0, eq: 1'b1, so: so};
    end else begin
      fld = '{lt: a_lt, gt: ~a_lt, eq: 1'b0, so: so};
    end
  end
endmodule

// File: rtl/addcmp_crfan.sv
module addcmp_crfan #(
  parameter int unsigned NF   = 8,
  parameter int unsigned FW   = 4,
  parameter int unsigned SELW = $clog2(NF)
) (
  input  logic [FW-1:0]    fld,
  input  logic [SELW-1:0]  sel,
  output logic [NF*FW-1:0] data,
  output logic [NF-1:0]    mask
);
  for (genvar g = 0; g < NF; g++) begin : g_nib
    assign data[g*FW +: FW] = fld;
    // field 0 is the most significant nibble
    assign mask[g] = (sel == SELW'(NF - 1 - g));
  end
endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
  import addcmp_pkg::*;
#(
  parameter int unsigned XLEN = DATA_W,
  parameter int unsigned NF   = NFIELD,
  parameter int unsigned FW   = FIELD_W,
  parameter int unsigned SELW = $clog2(NF),
  parameter int unsigned CRW  = NF * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            op_cmp,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            inv_a,
  input  logic            carry_in,
  input  logic            carry_en,
  input  logic            ov_en,
  input  logic            cmp_signed,
  input  logic            cmp_wide,
  input  logic [SELW-1:0] field_sel,
  input  logic            so_in,
  output logic            out_valid,
  output logic            sum_valid,
  output logic [XLEN-1:0] sum,
  output logic            ca,
  output logic            ca32,
  output logic            ca_upd,
  output logic            ov,
  output logic            ov32,
  output logic            ov_upd,
  output logic [CRW-1:0]  cr_data,
  output logic [NF-1:0]   cr_mask,
  output logic            cr_we
);
  logic            add_inv, add_cin;
  logic [XLEN-1:0] add_sum;
  logic            co_full, co_half, ovf_full, ovf_half;
  crf_t            fld;
  logic [CRW-1:0]  fan_data;
  logic [NF-1:0]   fan_mask;

  // a compare always forms B - A
  always_comb begin
    add_inv = op_cmp | inv_a;
    add_cin = op_cmp | carry_in;
  end

  addcmp_adder #(.W(XLEN)) u_adder (
    .a(opnd_a), .b(opnd_b), .inv(add_inv), .cin(add_cin),
    .sum(add_sum), .co_full(co_full), .co_half(co_half),
    .ov_full(ovf_full), .ov_half(ovf_half)
  );

  addcmp_cond #(.W(XLEN)) u_cond (
    .a(opnd_a), .b(opnd_b), .wide(cmp_wide), .sgn(cmp_signed),
    .co_full(co_full), .co_half(co_half), .so(so_in), .fld(fld)
  );

  addcmp_crfan #(.NF(NF), .FW(FW), .SELW(SELW)) u_fan (
    .fld(fld), .sel(field_sel), .data(fan_data), .mask(fan_mask)
  );

  // next-state for strobes
  logic nx_valid, nx_sum_valid, nx_ca_upd, nx_ov_upd, nx_cr_we;
  always_comb begin
    nx_valid     = in_valid;
    nx_sum_valid = in_valid & ~op_cmp;
    nx_ca_upd    = in_valid & ~op_cmp & carry_en;
    nx_ov_upd    = in_valid & ~op_cmp & ov_en;
    nx_cr_we     = in_valid & op_cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum_valid <= 1'b0;
      ca_upd    <= 1'b0;
      ov_upd    <= 1'b0;
      cr_we     <= 1'b0;
      sum       <= '0;
      ca        <= 1'b0;
      ca32      <= 1'b0;
      ov        <= 1'b0;
      ov32      <= 1'b0;
      cr_data   <= '0;
      cr_mask   <= '0;
    end else begin
      out_valid <= nx_valid;
      sum_valid <= nx_sum_valid;
      ca_upd    <= nx_ca_upd;
      ov_upd    <= nx_ov_upd;
      cr_we     <= nx_cr_we;
      if (in_valid) begin
        sum     <= add_sum;
        ca      <= co_full;
        ca32    <= co_half;
        ov      <= ovf_full;
        ov32    <= ovf_half;
        cr_data <= fan_data;
        cr_mask <= fan_mask;
      end
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !sum_valid && !cr_we && !ca_upd && !ov_upd));

  // R9
  cmp_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cr_we && (sum_valid || ca_upd || ov_upd)));

  // R8
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_mask) == 1);

  // R4
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $countones(cr_data[FW-1:1]) == 1);

  // R2
  flag_add_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_upd || ov_upd) |-> sum_valid);
endmodule

// File: tb/addcmp_unit_test.sv
`timescale 1ns/1ps
module addcmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, op_cmp, inv_a, carry_in, carry_en, ov_en;
  logic        cmp_signed, cmp_wide, so_in;
  logic [63:0] opnd_a, opnd_b;
  logic [2:0]  field_sel;
  logic        out_valid, sum_valid, ca, ca32, ca_upd, ov, ov32, ov_upd, cr_we;
  logic [63:0] sum;
  logic [31:0] cr_data;
  logic [7:0]  cr_mask;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  addcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_cmp(op_cmp),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .inv_a(inv_a), .carry_in(carry_in),
    .carry_en(carry_en), .ov_en(ov_en), .cmp_signed(cmp_signed),
    .cmp_wide(cmp_wide), .field_sel(field_sel), .so_in(so_in),
    .out_valid(out_valid), .sum_valid(sum_valid), .sum(sum), .ca(ca),
    .ca32(ca32), .ca_upd(ca_upd), .ov(ov), .ov32(ov32), .ov_upd(ov_upd),
    .cr_data(cr_data), .cr_mask(cr_mask), .cr_we(cr_we)
  );

  typedef struct {
    logic        is_cmp;
    logic [63:0] sum;
    logic        ca, ca32, ca_upd, ov, ov32, ov_upd;
    logic [31:0] data;
    logic [7:0]  mask;
    string       req;
  } exp_t;

  exp_t q[$];

  task automatic send(input logic cmp, input logic [63:0] a, input logic [63:0] b,
                      input logic inv, input logic cin, input logic cen, input logic oen,
                      input logic sgn, input logic wide, input logic [2:0] fs,
                      input logic so, input string req);
    exp_t e;
    logic [64:0] t64;
    logic [32:0] t32;
    logic [63:0] ae;
    logic        eq, lt;
    logic [3:0]  f;
    @(negedge clk);
    in_valid = 1'b1; op_cmp = cmp; opnd_a = a; opnd_b = b; inv_a = inv;
    carry_in = cin; carry_en = cen; ov_en = oen; cmp_signed = sgn;
    cmp_wide = wide; field_sel = fs; so_in = so;
    e = '{default: '0, req: req};
    e.is_cmp = cmp;
    if (cmp) begin
      if (wide) begin
        eq = (a == b);
        lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
      end else begin
        eq = (a[31:0] == b[31:0]);
        lt = sgn ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
      end
      f = eq ? {3'b001, so} : {lt, !lt, 1'b0, so};
      e.data = {8{f}};
      e.mask = 8'h80 >> fs;
    end else begin
      ae = inv ? ~a : a;
      t64 = {1'b0, ae} + {1'b0, b} + {64'd0, cin};
      t32 = {1'b0, ae[31:0]} + {1'b0, b[31:0]} + {32'd0, cin};
      e.sum = t64[63:0];
      e.ca = t64[64];
      e.ca32 = t32[32];
      e.ca_upd = cen;
      e.ov = (ae[63] == b[63]) && (t64[63] != ae[63]);
      e.ov32 = (ae[31] == b[31]) && (t32[31] != ae[31]);
      e.ov_upd = oen;
    end
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    logic bad;
    if (rst_n && out_valid) begin
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R10: out_valid=1 actual with nothing pending (expected 0)");
      end else begin
        e = q.pop_front();
        bad = 1'b0;
        if (e.is_cmp) begin
          if (!cr_we || cr_data !== e.data || cr_mask !== e.mask ||
              sum_valid || ca_upd || ov_upd) bad = 1'b1;
        end else begin
          if (!sum_valid || cr_we || sum !== e.sum || ca_upd !== e.ca_upd ||
              ov_upd !== e.ov_upd) bad = 1'b1;
          if (e.ca_upd && (ca !== e.ca || ca32 !== e.ca32)) bad = 1'b1;
          if (e.ov_upd && (ov !== e.ov || ov32 !== e.ov32)) bad = 1'b1;
        end
        if (bad) begin
          n_bad++;
          $display("FAIL %s: actual we=%b data=%h mask=%h sv=%b sum=%h ca=%b/%b/%b ov=%b/%b/%b expected we=%b data=%h mask=%h sum=%h ca=%b/%b/%b ov=%b/%b/%b",
                   e.req, cr_we, cr_data, cr_mask, sum_valid, sum, ca, ca32, ca_upd,
                   ov, ov32, ov_upd, e.is_cmp, e.data, e.mask, e.sum, e.ca, e.ca32,
                   e.ca_upd, e.ov, e.ov32, e.ov_upd);
        end
      end
    end else if (rst_n && (sum_valid || cr_we || ca_upd || ov_upd)) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10: strobe without out_valid sv=%b we=%b cu=%b ou=%b (expected 0)",
               sum_valid, cr_we, ca_upd, ov_upd);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_cmp = 1'b0; opnd_a = '0; opnd_b = '0;
    inv_a = 1'b0; carry_in = 1'b0; carry_en = 1'b0; ov_en = 1'b0;
    cmp_signed = 1'b0; cmp_wide = 1'b0; field_sel = '0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    n_chk++;
    if (out_valid || sum_valid || cr_we || ca_upd || ov_upd) begin
      n_bad++;
      $display("FAIL R11: strobes %b%b%b%b%b (expected 00000)",
               out_valid, sum_valid, cr_we, ca_upd, ov_upd);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (out_valid || sum_valid || cr_we || ca_upd || ov_upd) begin
      n_bad++;
      $display("FAIL R11: strobes after release %b%b%b%b%b (expected 00000)",
               out_valid, sum_valid, cr_we, ca_upd, ov_upd);
    end

    // R1 plain add and inverted add
    send(0, 64'd5, 64'd7, 0, 0, 1, 1, 0, 0, 0, 0, "R1");
    send(0, 64'd3, 64'd10, 1, 1, 1, 0, 0, 0, 0, 0, "R1");
    // R2 carries at both widths
    send(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    send(0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, 0, 0, "R2");
    send(0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3 overflow at each width, and disabled
    send(0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 1, 0, 0, 0, 0, "R3");
    send(0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 0, 1, 0, 0, 0, 0, "R3");
    send(0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 1, 1, 0, 0, 0, 0, "R3");
    send(0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    idle();
    idle();
    // R4 equality, both widths
    send(1, 64'h1234, 64'h1234, 0, 0, 0, 0, 1, 1, 2, 1, "R4");
    send(1, 64'h1_0000_0005, 64'h2_0000_0005, 0, 0, 0, 0, 1, 0, 4, 0, "R4");
    send(1, 64'h1_0000_0005, 64'h2_0000_0005, 0, 0, 0, 0, 1, 1, 4, 0, "R7");
    // R5 signed, top bits differ
    send(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1, 1, 1, 0, "R5");
    send(1, 64'h0000_0000_8000_0000, 64'd1, 0, 0, 0, 0, 1, 0, 5, 1, "R5");
    // R6 unsigned, top bits differ
    send(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 1, 6, 0, "R6");
    send(1, 64'd1, 64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 0, 6, 0, "R6");
    // R7 top bits equal, carry decides; 32-bit mode ignores upper half
    send(1, 64'h0000_0000_8000_0000, 64'd1, 0, 0, 0, 0, 1, 1, 3, 0, "R7");
    send(1, 64'd100, 64'd50, 0, 0, 0, 0, 0, 1, 3, 1, "R7");
    send(1, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 0, 0, 0, 0, 1, 0, 3, 0, "R7");
    send(1, 64'hF000_0000_0000_0002, 64'h0000_0000_0000_0009, 0, 0, 0, 0, 0, 0, 3, 0, "R7");
    // R8 mask ends
    send(1, 64'd9, 64'd2, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    send(1, 64'd9, 64'd2, 0, 0, 0, 0, 0, 1, 7, 1, "R8");
    idle();
    // R9 compare ignores add controls and raises no add strobes
    send(1, 64'd40, 64'd41, 1, 1, 1, 1, 0, 1, 2, 0, "R9");
    send(1, 64'd41, 64'd40, 0, 0, 1, 1, 1, 0, 2, 0, "R9");
    // R10 back-to-back mix then idle
    send(0, 64'd1, 64'd2, 0, 1, 1, 1, 0, 0, 0, 0, "R10");
    send(1, 64'd1, 64'd2, 0, 0, 0, 0, 1, 1, 0, 0, "R10");
    idle();
    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d results missing (expected 0)", q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule